// File: doc/BRIEF.md
# Multichannel UART FIFO Bus Window

This block is a host-bus slave that sits in front of four UART channels and gives software wide access to each channel's receive and transmit byte queues. A single 32-bit read can drain up to four received bytes, and a single 32-bit write can load four bytes for transmission. This cuts bus traffic to a quarter of what single-byte holding-register access needs. Each channel also has a paired window. Reads there return every received byte together with the line-status byte that was captured with it. The single-byte holding register is kept at the base of each channel region.

The queues are inside the block. The serialiser side of each channel is modelled as plain ports. On the receive side, one byte and its status byte are pushed per cycle. On the transmit side, one byte is popped per cycle and the head byte is presented. The host bus is a single-cycle request bus. Reads pop the queue on the request edge and return the data registered one cycle later.

Top module: `uart_fifo_window`

## Requirements
- R1: Address bits [11:10] select the channel and bits [9:0] are the offset inside that channel's 0x400-byte region. An access affects only the queues of the selected channel.
- R2: Offset 0x000 is the holding register. A read of any size pops one receive byte into lane 0 with the other lanes zero. A write of any size pushes only wdata_i[7:0] into the transmit queue.
- R3: A read anywhere in offsets 0x100–0x1FF pops N receive bytes, where N is 1, 2 or 4 for size_i 0, 1 or 2/3. Lane i (bits 8i+7:8i) holds the i-th oldest byte.
- R4: A write anywhere in offsets 0x100–0x1FF pushes N transmit bytes taken from lanes 0 upward, so lane 0 is transmitted first.
- R5: A read in offsets 0x200–0x3FF returns data/status pairs, oldest pair first. Each 16-bit half holds data in bits 7:0 and status in bits 15:8. A 16-bit read pops one entry and a 32-bit read pops two.
- R6: An 8-bit read of the paired window returns zero and pops nothing. Writes to the paired window are ignored.
- R7: If a read asks for more entries than the receive queue holds, the read pops only what is there. The missing lanes read zero, and a read of an empty queue returns zero without disturbing later ordering.
- R8: If a write carries more bytes than the transmit queue has room for, the bytes that fit are kept in order and the rest are dropped. The write then sets the channel's ovf_o bit, which stays set until reset.
- R9: Offsets 0x001–0x0FF are reserved. Reads there return zero and writes there are ignored.
- R10: rvalid_o pulses one cycle after a read request, carrying its data on rdata_o. rdata_o is zero in any cycle that does not follow a read.
- R11: After reset all queues are empty, tx_empty_o is all ones, ovf_o is zero, and rvalid_o and rdata_o are zero.
- R12: rx_push_i stores {rx_stat_i, rx_data_i} for the channel, and a push into a full receive queue (DEPTH entries) is dropped. tx_pop_i removes the head byte shown on tx_data_o, and a pop of an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 = byte, 1 = half-word, 2/3 = word |
| addr_i | input | 12 | Byte address: channel in [11:10], offset in [9:0] |
| wdata_i | input | 32 | Write data, byte lane i = bits 8i+7:8i |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rx_push_i | input | 4 | Per-channel receive push from the serialiser |
| rx_data_i | input | 4x8 | Per-channel received byte |
| rx_stat_i | input | 4x8 | Per-channel line-status byte for that received byte |
| tx_pop_i | input | 4 | Per-channel transmit pop from the serialiser |
| tx_data_o | output | 4x8 | Per-channel head byte of the transmit queue |
| tx_empty_o | output | 4 | Per-channel transmit queue empty |
| ovf_o | output | 4 | Per-channel sticky transmit overflow |

## Verification
The bench sweeps every channel against each window kind and each access width. Each channel receives a run of five queued bytes with distinct data and status values, then four reads follow. The sweep therefore covers full reads, a short read whose upper lanes must be zero, and reads of an empty queue. These cases expose lane-order mistakes, wrong pop counts per width, and any crossing of channels. The transmit side gets single writes of each width through both windows and is drained byte by byte, which shows whether lane 0 leaves first and whether the holding register takes only the low byte. Separate patterns cover the remaining cases:
- an overfilling burst, which shows truncation and the sticky flag;
- a ten-byte receive burst, which shows the full-queue drop;
- byte-wide reads of the paired window, writes to it, and accesses at reserved offsets, each followed by a read-back that proves nothing moved.

// File: rtl/uwin_pkg.sv
package uwin_pkg;
  typedef enum logic [1:0] {K_RSVD, K_HOLD, K_WIDE, K_PAIR} win_kind_e;
  localparam int unsigned REGION_W = 10;  // 0x400 bytes per channel
  localparam int unsigned LANES    = 4;
endpackage

// File: rtl/uwin_decode.sv
module uwin_decode
  import uwin_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned AW  = REGION_W + CHW
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [1:0]     size_i,
  output logic [CHW-1:0] ch_o,
  output win_kind_e      kind_o,
  output logic [2:0]     nbytes_o
);
  logic [REGION_W-1:0] off;
  assign off  = addr_i[REGION_W-1:0];
  assign ch_o = addr_i[REGION_W +: CHW];

  always_comb begin
    unique case (off[9:8])
      2'd0:    kind_o = (off[7:0] == 8'd0) ? K_HOLD : K_RSVD;
      2'd1:    kind_o = K_WIDE;
      default: kind_o = K_PAIR;
    endcase
    unique case (size_i)
      2'd0:    nbytes_o = 3'd1;
      2'd1:    nbytes_o = 3'd2;
      default: nbytes_o = 3'd4;
    endcase
  end
endmodule

// File: rtl/uwin_fifo.sv
// Queue with up to LANES pushes and pops per cycle; caller bounds both.
module uwin_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned LW = $clog2(LANES + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LW-1:0]             push_n_i,
  input  logic [LANES-1:0][W-1:0]   push_d_i,
  input  logic [LW-1:0]             pop_n_i,
  output logic [LANES-1:0][W-1:0]   head_o,
  output logic [CW-1:0]             count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] count_q;

  for (genvar i = 0; i < LANES; i++) begin : g_head
    assign head_o[i] = mem_q[rd_ptr_q + PW'(i)];
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < LANES; i++)
      if (LW'(i) < push_n_i) mem_q[wr_ptr_q + PW'(i)] <= push_d_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_q + PW'(pop_n_i);
      wr_ptr_q <= wr_ptr_q + PW'(push_n_i);
      count_q  <= count_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/uart_fifo_window.sv
module uart_fifo_window
  import uwin_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned AW  = REGION_W + CHW,
  localparam int unsigned CW  = $clog2(DEPTH + 1),
  localparam int unsigned LW  = $clog2(LANES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [1:0]            size_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic                  rvalid_o,
  input  logic [NCH-1:0]        rx_push_i,
  input  logic [NCH-1:0][7:0]   rx_data_i,
  input  logic [NCH-1:0][7:0]   rx_stat_i,
  input  logic [NCH-1:0]        tx_pop_i,
  output logic [NCH-1:0][7:0]   tx_data_o,
  output logic [NCH-1:0]        tx_empty_o,
  output logic [NCH-1:0]        ovf_o
);
  logic [CHW-1:0] dec_ch;
  win_kind_e      dec_kind;
  logic [2:0]     dec_nb;

  uwin_decode #(.NCH(NCH)) i_decode (
    .addr_i  (addr_i),
    .size_i  (size_i),
    .ch_o    (dec_ch),
    .kind_o  (dec_kind),
    .nbytes_o(dec_nb)
  );

  logic [NCH-1:0][31:0] ch_rdata;
  logic [NCH-1:0]       ovf_set;
  logic [NCH-1:0]       ovf_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic                   rd, wr;
    logic [LW-1:0]          rx_want, rx_pop, rx_push;
    logic [LW-1:0]          tx_want, tx_push, tx_pop;
    logic [CW-1:0]          rx_cnt, tx_cnt, tx_free;
    logic [LANES-1:0][15:0] rx_head, rx_in;
    logic [LANES-1:0][7:0]  tx_head, tx_in;

    assign rd = req_i && !we_i && (dec_ch == CHW'(c));
    assign wr = req_i &&  we_i && (dec_ch == CHW'(c));

    always_comb begin
      rx_want = '0;
      tx_want = '0;
      if (rd) begin
        unique case (dec_kind)
          K_HOLD:  rx_want = LW'(1);
          K_WIDE:  rx_want = LW'(dec_nb);
          K_PAIR:  rx_want = (dec_nb == 3'd1) ? '0 : LW'(dec_nb >> 1);
          default: rx_want = '0;
        endcase
      end
      if (wr) begin
        unique case (dec_kind)
          K_HOLD:  tx_want = LW'(1);
          K_WIDE:  tx_want = LW'(dec_nb);
          default: tx_want = '0;
        endcase
      end
    end

    // clamp to occupancy / free space
    assign rx_pop  = (CW'(rx_want) > rx_cnt) ? LW'(rx_cnt) : rx_want;
    assign tx_free = CW'(DEPTH) - tx_cnt;
    assign tx_push = (CW'(tx_want) > tx_free) ? LW'(tx_free) : tx_want;
    assign ovf_set[c] = CW'(tx_want) > tx_free;
    assign rx_push = (rx_push_i[c] && rx_cnt != CW'(DEPTH)) ? LW'(1) : '0;
    assign tx_pop  = (tx_pop_i[c] && tx_cnt != '0) ? LW'(1) : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign rx_in[i] = (i == 0) ? {rx_stat_i[c], rx_data_i[c]} : 16'h0;
      assign tx_in[i] = wdata_i[8*i +: 8];
      always_comb begin
        ch_rdata[c][8*i +: 8] = 8'h0;
        if (dec_kind == K_PAIR) begin
          if (LW'(i / 2) < rx_pop)
            ch_rdata[c][8*i +: 8] = (i % 2 == 1) ? rx_head[i/2][15:8] : rx_head[i/2][7:0];
        end else if (LW'(i) < rx_pop) begin
          ch_rdata[c][8*i +: 8] = rx_head[i][7:0];
        end
      end
    end

    uwin_fifo #(.W(16), .DEPTH(DEPTH), .LANES(LANES)) i_rx_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_n_i(rx_push),
      .push_d_i(rx_in),
      .pop_n_i (rx_pop),
      .head_o  (rx_head),
      .count_o (rx_cnt)
    );

    uwin_fifo #(.W(8), .DEPTH(DEPTH), .LANES(LANES)) i_tx_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_n_i(tx_push),
      .push_d_i(tx_in),
      .pop_n_i (tx_pop),
      .head_o  (tx_head),
      .count_o (tx_cnt)
    );

    assign tx_data_o[c]  = tx_head[0];
    assign tx_empty_o[c] = (tx_cnt == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      ovf_q    <= '0;
    end else begin
      rvalid_o <= req_i && !we_i;
      rdata_o  <= (req_i && !we_i) ? ch_rdata[dec_ch] : 32'h0;
      ovf_q    <= ovf_q | ovf_set;
    end
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/uwin_chk.sv
module uwin_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           we_i,
  input logic [1:0]     size_i,
  input logic [AW-1:0]  addr_i,
  input logic [31:0]    rdata_o,
  input logic           rvalid_o,
  input logic [NCH-1:0] tx_pop_i,
  input logic [NCH-1:0] tx_empty_o,
  input logic [NCH-1:0] ovf_o
);
  a_r10_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (!rvalid_o && rdata_o == 32'h0));

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o != '0) |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

  a_r6_pair_byte_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd0 && addr_i[9]) |=> (rdata_o == 32'h0));

  a_r9_rsvd_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[9:8] == 2'd0 && addr_i[7:0] != 8'd0) |=> (rdata_o == 32'h0));

  a_r6_pair_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[9] && tx_pop_i == '0) |=> $stable(tx_empty_o));
endmodule

bind uart_fifo_window uwin_chk #(.NCH(NCH), .AW(AW)) i_uwin_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .size_i    (size_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .tx_pop_i  (tx_pop_i),
  .tx_empty_o(tx_empty_o),
  .ovf_o     (ovf_o)
);

// File: tb/test_uart_fifo_window.sv
module test_uart_fifo_window;
  localparam int NCH = 4;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                req = 0, we = 0;
  logic [1:0]          size = 0;
  logic [11:0]         addr = 0;
  logic [31:0]         wdata = 0;
  logic [31:0]         rdata_o;
  logic                rvalid_o;
  logic [NCH-1:0]      rx_push = 0;
  logic [NCH-1:0][7:0] rx_data = '0, rx_stat = '0;
  logic [NCH-1:0]      tx_pop = 0;
  logic [NCH-1:0][7:0] tx_data_o;
  logic [NCH-1:0]      tx_empty_o, ovf_o;

  uart_fifo_window #(.NCH(NCH), .DEPTH(DEPTH)) i_uart_fifo_window (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_stat_i(rx_stat),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data_o), .tx_empty_o(tx_empty_o), .ovf_o(ovf_o)
  );

  int checks = 0, errors = 0;
  int seq = 1;
  logic [15:0] rxq [NCH][$];
  logic [7:0]  txq [NCH][$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rx_feed(int ch, int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d, s;
      d = 8'(seq);
      s = 8'(seq * 3 + ch + 8'h80);
      seq++;
      @(negedge clk);
      rx_push[ch] = 1; rx_data[ch] = d; rx_stat[ch] = s;
      @(negedge clk);
      rx_push[ch] = 0;
      if (rxq[ch].size() < DEPTH) rxq[ch].push_back({s, d});
    end
  endtask

  // kind: 0 reserved, 1 holding, 2 wide, 3 paired
  task automatic bus_read(int ch, logic [9:0] off, int kind, int sz, string tag);
    logic [31:0] exp;
    int n;
    bit shortq;
    exp = 0; shortq = 0;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (kind == 1) begin
      if (rxq[ch].size() > 0) exp[7:0] = rxq[ch].pop_front()[7:0];
      else shortq = 1;
    end else if (kind == 2) begin
      for (int i = 0; i < n; i++)
        if (rxq[ch].size() > 0) exp[8*i +: 8] = rxq[ch].pop_front()[7:0];
        else shortq = 1;
    end else if (kind == 3 && n > 1) begin
      for (int j = 0; j < n / 2; j++)
        if (rxq[ch].size() > 0) exp[16*j +: 16] = rxq[ch].pop_front();
        else shortq = 1;
    end
    @(negedge clk);
    req = 1; we = 0; size = 2'(sz); addr = {2'(ch), off};
    @(negedge clk);
    req = 0;
    chk("R10 rvalid", 32'(rvalid_o), 32'd1);
    chk(shortq ? "R7 short read" : tag, rdata_o, exp);
  endtask

  task automatic bus_write(int ch, logic [9:0] off, int kind, int sz, logic [31:0] wd);
    int n;
    n = (kind == 1) ? 1 : (kind == 2) ? ((sz == 0) ? 1 : (sz == 1) ? 2 : 4) : 0;
    for (int i = 0; i < n; i++)
      if (txq[ch].size() < DEPTH) txq[ch].push_back(wd[8*i +: 8]);
    @(negedge clk);
    req = 1; we = 1; size = 2'(sz); addr = {2'(ch), off}; wdata = wd;
    @(negedge clk);
    req = 0; we = 0;
    chk("R10 no read", {rdata_o[31:1], rvalid_o}, 32'd0);
  endtask

  task automatic tx_drain(int ch, string tag);
    while (txq[ch].size() > 0) begin
      chk(tag, {23'd0, tx_empty_o[ch], tx_data_o[ch]}, {24'd0, txq[ch][0]});
      tx_pop[ch] = 1;
      @(negedge clk);
      tx_pop[ch] = 0;
      void'(txq[ch].pop_front());
    end
    chk({tag, " empty"}, 32'(tx_empty_o[ch]), 32'd1);
  endtask

  task automatic rx_drain(int ch, string tag);
    while (rxq[ch].size() > 0) bus_read(ch, 10'h100, 2, 2, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 rvalid", 32'(rvalid_o), 0);
    chk("R11 rdata", rdata_o, 0);
    chk("R11 tx_empty", 32'(tx_empty_o), 32'hF);
    chk("R11 ovf", 32'(ovf_o), 0);

    // RX sweep: channel x window x width (R1 R2 R3 R5 R7)
    for (int ch = 0; ch < NCH; ch++)
      for (int kind = 1; kind <= 3; kind++)
        for (int sz = 0; sz < 3; sz++) begin
          logic [9:0] off;
          off = (kind == 1) ? 10'h000 : (kind == 2) ? 10'(10'h100 + sz * 10'h44)
              : ((sz % 2 == 0) ? 10'h200 : 10'h3FC);
          rx_feed(ch, 5);
          for (int r = 0; r < 4; r++)
            bus_read(ch, off, kind, sz,
                     kind == 1 ? "R2 R1 hold read" : kind == 2 ? "R3 R1 wide read" : "R5 R1 pair read");
        end
    for (int ch = 0; ch < NCH; ch++) rx_drain(ch, "R3 drain");

    // TX sweep (R2 R4)
    for (int ch = 0; ch < NCH; ch++)
      for (int kind = 1; kind <= 2; kind++)
        for (int sz = 0; sz < 3; sz++) begin
          logic [31:0] wd;
          wd = {8'(seq + 3), 8'(seq + 2), 8'(seq + 1), 8'(seq)} ^ {4{8'(ch << 6)}};
          seq += 4;
          bus_write(ch, kind == 1 ? 10'h000 : 10'h1F0, kind, sz, wd);
          tx_drain(ch, kind == 1 ? "R2 hold write" : "R4 wide write");
        end
    chk("R8 no overflow yet", 32'(ovf_o), 0);

    // R9 reserved
    bus_write(2, 10'h004, 0, 2, 32'hDEADBEEF);
    chk("R9 reserved write ignored", 32'(tx_empty_o[2]), 1);
    rx_feed(2, 1);
    bus_read(2, 10'h0F0, 0, 2, "R9 reserved read");
    bus_read(2, 10'h100, 2, 0, "R9 nothing popped");

    // R6 paired window: byte read and writes
    bus_write(3, 10'h200, 3, 2, 32'h11223344);
    chk("R6 pair write ignored", 32'(tx_empty_o[3]), 1);
    rx_feed(3, 2);
    bus_read(3, 10'h204, 3, 0, "R6 byte pair read");
    bus_read(3, 10'h100, 2, 2, "R6 nothing popped");
    bus_read(3, 10'h000, 1, 0, "R7 empty hold read");

    // R12 RX full drop
    rx_feed(0, 10);
    rx_drain(0, "R12 rx full drop");

    // R8 TX overflow on channel 1
    bus_write(1, 10'h100, 2, 2, 32'h03020100);
    bus_write(1, 10'h100, 2, 2, 32'h07060504);
    bus_write(1, 10'h100, 2, 2, 32'h0B0A0908);
    chk("R8 ovf set", 32'(ovf_o), 32'b0010);
    tx_drain(1, "R8 truncated order");
    chk("R8 ovf sticky", 32'(ovf_o), 32'b0010);

    // R12 pop of empty TX queue
    @(negedge clk);
    tx_pop = '1;
    @(negedge clk);
    tx_pop = '0;
    chk("R12 empty pop", 32'(tx_empty_o), 32'hF);
    bus_write(0, 10'h000, 1, 0, 32'h000000A5);
    tx_drain(0, "R12 after empty pop");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule